// File: doc/BRIEF.md
# Supply Supervisor with Reset Hold and Watchdog

This block watches a digital supply-good flag, produced by an external threshold comparator, and drives an active-low processor reset. Whenever the flag is false, reset is asserted. Once the flag turns true, reset is held for a programmable number of clock cycles and then released. If the flag drops during that hold, the count starts over.

After reset releases, a watchdog expects the processor to toggle a service input. A rising edge and a falling edge are both valid services. The service input is synchronised, and each detected edge clears a prescaler and an 8-bit period counter. If the counter runs out first, the active-low watchdog output is latched low. It stays low until the next service edge or until reset is asserted. While reset is active, the watchdog output is forced high and both counters are held at zero.

The reset sequencer has three named states: DOWN, HOLD and RUN. Its transitions are:
- power-lost (any state to DOWN),
- power-good (DOWN to HOLD),
- hold-done (HOLD to RUN, or DOWN straight to RUN when the hold length is at most one).

The watchdog has three named states: HELD, RUN and TRIP. Its transitions are:
- reset-seen (any state to HELD),
- released (HELD to RUN),
- service (RUN to RUN, or TRIP to RUN),
- expiry (RUN to TRIP).

Top module: `sup_monitor_top`

## Requirements
- R1: At every clock edge where `supply_ok_i` is sampled low, `rst_no` is low during the following cycle.
- R2: With hold length H (H=0 behaves as 1), `rst_no` goes high right after the H-th consecutive edge that samples `supply_ok_i` high.
- R3: If `supply_ok_i` is sampled low during the hold, the count of good edges restarts from zero. The full H edges are then needed again.
- R4: A rising edge and a falling edge of `wdi_i` both count as a service. The change is acted on at the third clock edge after the edge that first samples it (two synchroniser flops, then an edge compare). Each service restarts the watchdog period.
- R5: With prescale P (P=0 behaves as 1), `wdo_no` goes low right after 256·P clock edges pass with reset released and no service. The count starts from the first edge after release or from the last service edge.
- R6: Once low, `wdo_no` stays low until a service edge is acted on or reset is asserted.
- R7: While `rst_no` is low, `wdo_no` is high and the watchdog counters are held at zero. Counting begins on the first edge after `rst_no` rises.
- R8: Service edges acted on while reset is active have no effect on the timeout measured after release.
- R9: While `rst_ni` is low, `rst_no` is low and `wdo_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low initialisation of the block's own registers |
| supply_ok_i | input | 1 | Supply-good flag from the external comparator, synchronous to `clk_i` |
| wdi_i | input | 1 | Watchdog service input from the processor (asynchronous) |
| hold_len_i | input | HOLD_W | Reset hold length in clock cycles (0 treated as 1) |
| wd_prescale_i | input | PRE_W | Clocks per watchdog tick (0 treated as 1) |
| rst_no | output | 1 | Active-low reset to the processor |
| wdo_no | output | 1 | Active-low watchdog expiry output |

## Verification
The reset output follows a sampled supply-good value one cycle later. It rises right after the H-th good edge. The watchdog output follows a `wdi_i` change on the third edge after that change is first sampled. It falls exactly 256·P edges after release or after the last acted-on service.

A cycle-level reference model in the bench advances on the same edges as the design. It derives these delays from the requirements alone. The bench drives inputs and compares outputs on the falling clock edge, so every sample falls half a cycle after the edge where the result became due. Directed checks count edges explicitly to the first cycle where each result must be visible, and to the cycle just before it.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        RS_DOWN = 2'd0,
        RS_HOLD = 2'd1,
        RS_RUN  = 2'd2
    } rst_state_e;

    typedef enum logic [1:0] {
        WD_HELD = 2'd0,
        WD_RUN  = 2'd1,
        WD_TRIP = 2'd2
    } wd_state_e;

endpackage

// File: rtl/sup_edge_sync.sv
module sup_edge_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wdi_i,
    output logic svc_o
);
    // stages 0..SYNC_N-1 synchronise, stage SYNC_N keeps the previous value
    logic [SYNC_N:0] stage_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= 1'b0;
        else         stage_q[0] <= wdi_i;
    end

    for (genvar g = 1; g <= SYNC_N; g++) begin : g_chain
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[g] <= 1'b0;
            else         stage_q[g] <= stage_q[g-1];
        end
    end

    assign svc_o = stage_q[SYNC_N-1] ^ stage_q[SYNC_N];

    if (SYNC_N == 2) begin : g_chk
        // R4: a pulse only follows a real change of the input, either polarity
        a_r4_edge_from_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
            svc_o |-> ($past(wdi_i, 2) != $past(wdi_i, 3)));
    end
endmodule

// File: rtl/sup_reset_seq.sv
module sup_reset_seq
    import sup_pkg::*;
#(
    parameter int HOLD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              supply_ok_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    output logic              rst_run_o
);
    localparam int CW = HOLD_W + 1;

    rst_state_e        state_q, state_d;
    logic [HOLD_W-1:0] cnt_q, cnt_d;
    logic [HOLD_W-1:0] hold_eff;
    logic              reach;

    assign hold_eff = (hold_len_i == '0) ? HOLD_W'(1) : hold_len_i;
    assign reach    = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, hold_eff};

    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        if (!supply_ok_i) begin
            state_d = RS_DOWN;                      // power-lost
        end else begin
            unique case (state_q)
                RS_DOWN: begin
                    state_d = reach ? RS_RUN : RS_HOLD; // power-good / hold-done
                    cnt_d   = HOLD_W'(1);
                end
                RS_HOLD: begin
                    state_d = reach ? RS_RUN : RS_HOLD; // hold-done
                    cnt_d   = cnt_q + HOLD_W'(1);
                end
                RS_RUN:  state_d = RS_RUN;
                default: state_d = RS_DOWN;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RS_DOWN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        rst_run_o = (state_q == RS_RUN);
    end

    // R3: a bad supply sample clears the hold progress
    a_r3_hold_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supply_ok_i |=> (cnt_q == '0 && state_q == RS_DOWN));
    // R2: release only happens after at least one good sample
    a_r2_release_on_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_run_o) |-> $past(supply_ok_i));
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
    import sup_pkg::*;
#(
    parameter int PRE_W = 12,
    parameter int WD_W  = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rst_act_i,
    input  logic             svc_i,
    input  logic [PRE_W-1:0] prescale_i,
    output logic             wdo_no
);
    localparam logic [WD_W-1:0] WD_FULL = {WD_W{1'b1}};

    wd_state_e         state_q, state_d;
    logic [PRE_W-1:0]  pre_q;
    logic [WD_W-1:0]   wd_q;
    logic [PRE_W-1:0]  pre_eff;
    logic              tick;

    assign pre_eff = (prescale_i == '0) ? PRE_W'(1) : prescale_i;
    assign tick    = (pre_q == pre_eff - PRE_W'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
            wd_q  <= '0;
        end else if (rst_act_i || svc_i) begin
            pre_q <= '0;
            wd_q  <= '0;
        end else if (tick) begin
            pre_q <= '0;
            wd_q  <= wd_q + WD_W'(1);
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        if (rst_act_i) begin
            state_d = WD_HELD;                          // reset-seen
        end else begin
            unique case (state_q)
                WD_HELD: state_d = WD_RUN;              // released
                WD_RUN: begin
                    if (svc_i)                      state_d = WD_RUN;  // service
                    else if (tick && wd_q == WD_FULL) state_d = WD_TRIP; // expiry
                end
                WD_TRIP: if (svc_i) state_d = WD_RUN;   // service
                default: state_d = WD_HELD;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= WD_HELD;
        else         state_q <= state_d;
    end

    always_comb begin
        wdo_no = !((state_q == WD_TRIP) && !rst_act_i);
    end

    // R7: counters sit at zero after any cycle with reset active
    a_r7_counters_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_act_i |=> (pre_q == '0 && wd_q == '0));
    // R5: expiry only from a completed period
    a_r5_trip_at_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(state_q == WD_TRIP) |-> ($past(wd_q) == WD_FULL && $past(tick)));
    // R4: a service outside reset restarts the period
    a_r4_service_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (svc_i && !rst_act_i) |=> (wd_q == '0 && pre_q == '0 && state_q == WD_RUN));
endmodule

// File: rtl/sup_monitor_top.sv
module sup_monitor_top #(
    parameter int HOLD_W = 16,
    parameter int PRE_W  = 12,
    parameter int SYNC_N = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              supply_ok_i,
    input  logic              wdi_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    input  logic [PRE_W-1:0]  wd_prescale_i,
    output logic              rst_no,
    output logic              wdo_no
);
    localparam int WD_W = 8;

    logic svc;
    logic rst_run;

    sup_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wdi_i  (wdi_i),
        .svc_o  (svc)
    );

    sup_reset_seq #(.HOLD_W(HOLD_W)) u_rseq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .supply_ok_i (supply_ok_i),
        .hold_len_i  (hold_len_i),
        .rst_run_o   (rst_run)
    );

    sup_wdog #(.PRE_W(PRE_W), .WD_W(WD_W)) u_wdog (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rst_act_i  (!rst_run),
        .svc_i      (svc),
        .prescale_i (wd_prescale_i),
        .wdo_no     (wdo_no)
    );

    assign rst_no = rst_run;

    // R1: bad supply sample gives reset in the next cycle
    a_r1_supply_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supply_ok_i |=> !rst_no);
    // R7: watchdog output high whenever reset is active
    a_r7_wdo_high_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rst_no |-> wdo_no);
    // R6: a latched expiry holds without service or supply loss
    a_r6_trip_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_no && !wdo_no && !svc && supply_ok_i) |=> !wdo_no);
    // R9: initialisation state
    a_r9_init_state: assert property (@(posedge clk_i)
        !rst_ni |-> (!rst_no && wdo_no));
endmodule

// File: tb/sup_monitor_top_tb_top.sv
module sup_monitor_top_tb_top;
    localparam int HOLD_W = 16;
    localparam int PRE_W  = 12;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              supply_ok_i = 1'b0;
    logic              wdi_i = 1'b0;
    logic [HOLD_W-1:0] hold_len_i = HOLD_W'(5);
    logic [PRE_W-1:0]  wd_prescale_i = PRE_W'(1);
    logic              rst_no, wdo_no;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    string rtag = "R1";
    string wtag = "R7";

    always #10 clk_i = ~clk_i;   // 50 MHz

    sup_monitor_top #(.HOLD_W(HOLD_W), .PRE_W(PRE_W)) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i), .wdi_i(wdi_i),
        .hold_len_i(hold_len_i), .wd_prescale_i(wd_prescale_i),
        .rst_no(rst_no), .wdo_no(wdo_no)
    );

    // ---------------- reference model (from the requirements) ----------------
    bit m_rst, m_wd, h1, h2, h3;
    int hold_n, elapsed;

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic bit exp_wdo(bit r, bit w);
        return r ? w : 1'b1;     // R7: forced high during reset
    endfunction

    always @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            m_rst = 0; m_wd = 1; h1 = 0; h2 = 0; h3 = 0; hold_n = 0; elapsed = 0;
        end else begin
            bit svc;
            svc = h2 ^ h3;            // R4: acted on third edge after first sample
            h3 = h2; h2 = h1; h1 = wdi_i;
            if (!m_rst)   begin elapsed = 0; m_wd = 1; end
            else if (svc) begin elapsed = 0; m_wd = 1; end
            else begin
                elapsed++;
                if (elapsed == 256 * eff(int'(wd_prescale_i))) m_wd = 0;
            end
            if (!supply_ok_i) begin hold_n = 0; m_rst = 0; end
            else if (!m_rst) begin
                hold_n++;
                if (hold_n >= eff(int'(hold_len_i))) m_rst = 1;
            end
        end
    end

    task automatic check(bit act, bit exp, string req, string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, half a cycle after the edge
    always @(negedge clk_i) begin
        if (rst_ni && !done) begin
            check(rst_no, m_rst, rtag, "rst_no vs model");
            check(wdo_no, exp_wdo(m_rst, m_wd), wtag, "wdo_no vs model");
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        n_checks++; n_errors++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        // R9: initialisation
        step(3);
        check(rst_no, 1'b0, "R9", "rst_no in init");
        check(wdo_no, 1'b1, "R9", "wdo_no in init");
        rst_ni = 1'b1;
        step(4);
        check(rst_no, 1'b0, "R1", "rst_no supply bad");

        // R2: hold of 5 edges
        rtag = "R2"; supply_ok_i = 1'b1;
        step(4); check(rst_no, 1'b0, "R2", "before 5th good edge");
        step(1); check(rst_no, 1'b1, "R2", "after 5th good edge");

        // R5: timeout 256 edges at P=1
        wtag = "R5";
        step(255); check(wdo_no, 1'b1, "R5", "edge 255");
        step(1);   check(wdo_no, 1'b0, "R5", "edge 256");
        // R6: latched
        wtag = "R6";
        step(100); check(wdo_no, 1'b0, "R6", "latched low");
        // R4: rising edge service
        wtag = "R4"; wdi_i = 1'b1;
        step(2); check(wdo_no, 1'b0, "R4", "rise before acting edge");
        step(1); check(wdo_no, 1'b1, "R4", "rise acted");
        // R4: falling edge service
        step(50); wdi_i = 1'b0;
        step(258); check(wdo_no, 1'b1, "R4", "fall restarted period");
        step(1);   check(wdo_no, 1'b0, "R4", "expiry after fall service");

        // R7/R8: reset clears trip; edges in reset ignored
        wtag = "R7"; supply_ok_i = 1'b0;
        step(1); check(rst_no, 1'b0, "R1", "supply drop");
        check(wdo_no, 1'b1, "R7", "forced high in reset");
        wtag = "R8"; wdi_i = 1'b1; step(3); wdi_i = 1'b0; step(6);
        hold_len_i = HOLD_W'(3); supply_ok_i = 1'b1;
        step(3); check(rst_no, 1'b1, "R2", "hold 3");
        step(255); check(wdo_no, 1'b1, "R8", "edge 255 after release");
        step(1);   check(wdo_no, 1'b0, "R8", "edge 256 after release");

        // R3: drop during hold restarts
        rtag = "R3"; supply_ok_i = 1'b0; step(2);
        supply_ok_i = 1'b1; step(2);
        supply_ok_i = 1'b0; step(1);
        supply_ok_i = 1'b1; step(2); check(rst_no, 1'b0, "R3", "restarted hold");
        step(1); check(rst_no, 1'b1, "R3", "full hold after restart");

        // corner: H=0 and P=0 act as 1
        rtag = "R2"; wtag = "R5"; supply_ok_i = 1'b0; step(1);
        hold_len_i = '0; wd_prescale_i = '0; supply_ok_i = 1'b1;
        step(1); check(rst_no, 1'b1, "R2", "H=0 one edge");
        step(255); check(wdo_no, 1'b1, "R5", "P=0 edge 255");
        step(1);   check(wdo_no, 1'b0, "R5", "P=0 edge 256");

        // P=3
        supply_ok_i = 1'b0; step(1);
        hold_len_i = HOLD_W'(2); wd_prescale_i = PRE_W'(3); supply_ok_i = 1'b1;
        step(2); check(rst_no, 1'b1, "R2", "hold 2");
        step(767); check(wdo_no, 1'b1, "R5", "P=3 edge 767");
        step(1);   check(wdo_no, 1'b0, "R5", "P=3 edge 768");

        // constrained random
        rtag = "R2"; wtag = "R5";
        for (int seg = 0; seg < 12; seg++) begin
            int tog_div;
            tog_div = ($urandom % 2 == 0) ? 60 : 400;
            for (int c = 0; c < 700; c++) begin
                if (supply_ok_i) begin
                    if ($urandom % 500 == 0) supply_ok_i = 1'b0;
                end else begin
                    hold_len_i    = HOLD_W'($urandom % 16);
                    wd_prescale_i = PRE_W'($urandom % 3);
                    if ($urandom % 8 == 0) supply_ok_i = 1'b1;
                end
                if ($urandom % tog_div == 0) wdi_i = ~wdi_i;
                step(1);
            end
        end
        finish_run();
    end
endmodule